// File: doc/BRIEF.md
# Target Read Burst Disconnect Controller

This block serves target-mode read bursts on a PCI-style bus. The data comes from an internal memory path. An initiator presents a read request with a start address, the number of 32-bit words it wants and a flag that marks the target as DRAM. The block works out how many words it may serve before it has to stop. It clears its local read FIFO and then places one read request, with an address and a byte size, on the internal bus. The words that come back are queued in the FIFO and handed to the bus side one beat at a time. Each beat goes through a byte-lane swap stage that can be switched on or off.

The block always stops a DRAM read after 16 bytes, which is four beats. It stops any read when the running address reaches a 64-byte aligned address. When it stops a burst early, it raises a disconnect flag together with the last permitted beat. The initiator then retries from the next address. A 32-byte DRAM read from 0x00 is therefore served as a 16-byte piece at 0x00 followed by a 16-byte piece at 0x10. When no word is buffered, the block inserts wait states. It never presents stale data.

Top module: `tgt_rd_disc_ctrl`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle until the burst has ended.
- R2: In the cycle after a request is taken, `fifo_flush` is high for exactly one cycle. This empties the read FIFO. `ireq_valid` rises only in the cycle after that flush.
- R3: The internal request carries the start address with bits 1:0 cleared. Its size in bytes is four times the granted word count. Address and size stay stable, and `ireq_valid` stays high, until `ireq_ready` is seen.
- R4: For a DRAM request (`req_is_dram` = 1), the granted count is at most 4 words (16 bytes).
- R5: The granted count never carries the running address past the next 64-byte aligned address. This holds even when the burst starts at an offset inside a 64-byte block.
- R6: The granted count is the minimum of the requested count and the limits from R4 and R5. A requested count of 0 is served as 1 word.
- R7: `out_last` is high on the final granted beat. `out_disc` is high on that same beat only when the granted count is smaller than the effective requested count. After that beat is accepted, the block is idle again.
- R8: With `swap_en` = 1, output byte k is byte 3-k of the stored word (bits 7:0 take bits 31:24, and so on). With `swap_en` = 0, the word passes unchanged.
- R9: `out_valid` is low while the FIFO holds no word. A presented beat stays presented until `bus_rdy` accepts it.
- R10: Beats are presented in arrival order. Beat n carries the word returned for address start + 4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swap_en | input | 1 | Byte-lane reversal enable, kept static during a burst |
| req_valid | input | 1 | Target read request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address of the read |
| req_len | input | LEN_W | Requested number of 32-bit words (0 means 1) |
| req_is_dram | input | 1 | Target of the read is DRAM |
| fifo_flush | output | 1 | One-cycle clear of the read FIFO |
| ireq_valid | output | 1 | Internal read request present |
| ireq_ready | input | 1 | Internal bus takes the request |
| ireq_addr | output | ADDR_W | Word-aligned start address of the internal read |
| ireq_size | output | $clog2(BOUND_BYTES/4+1)+2 | Internal read size in bytes |
| iresp_valid | input | 1 | Returned word present |
| iresp_data | input | 32 | Returned word |
| out_valid | output | 1 | Bus beat presented |
| bus_rdy | input | 1 | Bus side accepts the presented beat |
| out_data | output | 32 | Beat data after the lane swap |
| out_last | output | 1 | Final beat of the granted burst |
| out_disc | output | 1 | Disconnect with this data beat |

## Verification
Several rules are checked by the assertions on every cycle:
- the request handshake and the flush-then-issue order,
- the stability of a pending internal request,
- the DRAM beat cap and the 64-byte crossing,
- the pairing of disconnect with the final beat,
- that a beat is held while the bus side stalls.

Other behaviours need the bench's scenarios and its cycle-accurate model:
- the exact grant arithmetic, including the zero-length and offset starts,
- the split of a 32-byte DRAM read into two pieces,
- the byte order with the swap on and off,
- the word-for-address data order when the memory and the bus side both insert gaps.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FLUSH = 2'd1,
        PH_ISSUE = 2'd2,
        PH_XFER  = 2'd3
    } rbd_phase_e;

endpackage

// File: rtl/rbd_fifo.sv
module rbd_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != (AW+1)'(DEPTH)) && !flush;
        do_pop  = pop && (st_q.cnt != '0) && !flush;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = ptr_inc(st_q.wr);
            if (do_pop)  st_d.rd = ptr_inc(st_q.rd);
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + (AW+1)'(1);
                2'b01:   st_d.cnt = st_q.cnt - (AW+1)'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= push_data;
    end

    assign head  = mem[st_q.rd];
    assign empty = (st_q.cnt == '0);

endmodule

// File: rtl/rbd_lane_swap.sv
module rbd_lane_swap #(
    parameter int BYTES = 4
) (
    input  logic               en,
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign dout[8*b +: 8] = en ? din[8*(BYTES-1-b) +: 8] : din[8*b +: 8];
    end
endmodule

// File: rtl/rbd_grant_calc.sv
module rbd_grant_calc #(
    parameter int LEN_W       = 5,
    parameter int BOUND_WORDS = 16,
    parameter int DRAM_WORDS  = 4
) (
    input  logic [$clog2(BOUND_WORDS)-1:0]   word_off,
    input  logic [LEN_W-1:0]                 req_len,
    input  logic                             is_dram,
    output logic [$clog2(BOUND_WORDS+1)-1:0] grant,
    output logic                             disc_need
);
    localparam int G_W   = $clog2(BOUND_WORDS + 1);
    localparam int CMP_W = ((LEN_W > G_W) ? LEN_W : G_W) + 1;

    logic [CMP_W-1:0] eff_len, to_bound, limit;

    always_comb begin
        eff_len   = (req_len == '0) ? CMP_W'(1) : CMP_W'(req_len);
        to_bound  = CMP_W'(BOUND_WORDS) - CMP_W'(word_off);
        limit     = (is_dram && (CMP_W'(DRAM_WORDS) < to_bound)) ? CMP_W'(DRAM_WORDS) : to_bound;
        grant     = (eff_len < limit) ? G_W'(eff_len) : G_W'(limit);
        disc_need = (eff_len > limit);
    end
endmodule

// File: rtl/tgt_rd_disc_ctrl.sv
module tgt_rd_disc_ctrl #(
    parameter int ADDR_W      = 32,
    parameter int LEN_W       = 5,
    parameter int BOUND_BYTES = 64,
    parameter int DRAM_BYTES  = 16,
    parameter int FIFO_DEPTH  = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  swap_en,
    input  logic                                  req_valid,
    output logic                                  req_ready,
    input  logic [ADDR_W-1:0]                     req_addr,
    input  logic [LEN_W-1:0]                      req_len,
    input  logic                                  req_is_dram,
    output logic                                  fifo_flush,
    output logic                                  ireq_valid,
    input  logic                                  ireq_ready,
    output logic [ADDR_W-1:0]                     ireq_addr,
    output logic [$clog2(BOUND_BYTES/4+1)+1:0]    ireq_size,
    input  logic                                  iresp_valid,
    input  logic [31:0]                           iresp_data,
    output logic                                  out_valid,
    input  logic                                  bus_rdy,
    output logic [31:0]                           out_data,
    output logic                                  out_last,
    output logic                                  out_disc
);
    import rbd_pkg::*;

    localparam int BOUND_WORDS = BOUND_BYTES / 4;
    localparam int DRAM_WORDS  = DRAM_BYTES / 4;
    localparam int OFF_W       = $clog2(BOUND_WORDS);
    localparam int G_W         = $clog2(BOUND_WORDS + 1);

    typedef struct packed {
        rbd_phase_e        phase;
        logic [ADDR_W-1:0] addr;
        logic [G_W-1:0]    left;
        logic              disc;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [G_W-1:0] grant;
    logic           disc_need;
    logic           fifo_empty;
    logic [31:0]    fifo_head;
    logic           beat_go;
    logic           unused_low_bits;

    assign unused_low_bits = ^req_addr[1:0];

    rbd_grant_calc #(
        .LEN_W      (LEN_W),
        .BOUND_WORDS(BOUND_WORDS),
        .DRAM_WORDS (DRAM_WORDS)
    ) i_grant (
        .word_off (req_addr[OFF_W+1:2]),
        .req_len  (req_len),
        .is_dram  (req_is_dram),
        .grant    (grant),
        .disc_need(disc_need)
    );

    rbd_fifo #(
        .WIDTH(32),
        .DEPTH(FIFO_DEPTH)
    ) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (fifo_flush),
        .push     (iresp_valid),
        .push_data(iresp_data),
        .pop      (beat_go),
        .head     (fifo_head),
        .empty    (fifo_empty)
    );

    rbd_lane_swap #(.BYTES(4)) i_swap (
        .en  (swap_en),
        .din (fifo_head),
        .dout(out_data)
    );

    always_comb begin
        st_d       = st_q;
        fifo_flush = 1'b0;
        ireq_valid = 1'b0;
        req_ready  = (st_q.phase == PH_IDLE);
        out_valid  = (st_q.phase == PH_XFER) && !fifo_empty;
        beat_go    = out_valid && bus_rdy;
        out_last   = out_valid && (st_q.left == G_W'(1));
        out_disc   = out_last && st_q.disc;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_FLUSH;
                    st_d.addr  = {req_addr[ADDR_W-1:2], 2'b00};
                    st_d.left  = grant;
                    st_d.disc  = disc_need;
                end
            end
            PH_FLUSH: begin
                fifo_flush = 1'b1;
                st_d.phase = PH_ISSUE;
            end
            PH_ISSUE: begin
                ireq_valid = 1'b1;
                if (ireq_ready) st_d.phase = PH_XFER;
            end
            PH_XFER: begin
                if (beat_go) begin
                    st_d.left = st_q.left - G_W'(1);
                    st_d.addr = st_q.addr + ADDR_W'(4);
                    if (st_q.left == G_W'(1)) st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ireq_addr = st_q.addr;
    assign ireq_size = {st_q.left, 2'b00};

endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
    parameter int BOUND_BYTES = 64,
    parameter int DRAM_BYTES  = 16,
    parameter int SIZE_W      = 7
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                req_valid,
    input logic                                req_ready,
    input logic [$clog2(BOUND_BYTES)-3:0]      req_woff,
    input logic                                req_is_dram,
    input logic                                fifo_flush,
    input logic                                ireq_valid,
    input logic                                ireq_ready,
    input logic [SIZE_W-1:0]                   ireq_size,
    input logic                                ireq_addr_lsb,
    input logic                                out_valid,
    input logic                                bus_rdy,
    input logic                                out_last,
    input logic                                out_disc
);
    localparam int WO_W  = $clog2(BOUND_BYTES) - 2;
    localparam int DRAM_WORDS = DRAM_BYTES / 4;

    logic            dram_t;
    logic [WO_W-1:0] run_woff;
    logic [SIZE_W-1:0] beats;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dram_t   <= 1'b0;
            run_woff <= '0;
            beats    <= '0;
        end else if (req_valid && req_ready) begin
            dram_t   <= req_is_dram;
            run_woff <= req_woff;
            beats    <= '0;
        end else if (out_valid && bus_rdy) begin
            run_woff <= run_woff + WO_W'(1);
            beats    <= beats + SIZE_W'(1);
        end
    end

    assert_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_flush_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> fifo_flush);

    assert_flush_before_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ireq_valid) |-> $past(fifo_flush));

    assert_issue_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ireq_valid && !ireq_ready) |=> (ireq_valid && $stable(ireq_size) && $stable(ireq_addr_lsb)));

    assert_dram_beats_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && dram_t) |-> (beats < SIZE_W'(DRAM_WORDS)));

    assert_dram_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ireq_valid && dram_t) |-> (ireq_size <= SIZE_W'(DRAM_BYTES)));

    assert_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (run_woff == {WO_W{1'b1}})) |-> out_last);

    assert_size_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ireq_valid |-> ((ireq_size != '0) && (ireq_size <= SIZE_W'(BOUND_BYTES))));

    assert_disc_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_disc |-> (out_last && out_valid));

    assert_beat_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !bus_rdy) |=> out_valid);

endmodule

bind tgt_rd_disc_ctrl rbd_checker #(
    .BOUND_BYTES(BOUND_BYTES),
    .DRAM_BYTES (DRAM_BYTES),
    .SIZE_W     ($clog2(BOUND_BYTES/4+1)+2)
) i_rbd_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_woff     (req_addr[$clog2(BOUND_BYTES)-1:2]),
    .req_is_dram  (req_is_dram),
    .fifo_flush   (fifo_flush),
    .ireq_valid   (ireq_valid),
    .ireq_ready   (ireq_ready),
    .ireq_size    (ireq_size),
    .ireq_addr_lsb(ireq_addr[2]),
    .out_valid    (out_valid),
    .bus_rdy      (bus_rdy),
    .out_last     (out_last),
    .out_disc     (out_disc)
);

// File: tb/test_tgt_rd_disc_ctrl.sv
`timescale 1ns/1ps
module test_tgt_rd_disc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        swap_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_len = '0;
    logic        req_is_dram = 1'b0;
    logic        fifo_flush;
    logic        ireq_valid;
    logic        ireq_ready = 1'b0;
    logic [31:0] ireq_addr;
    logic [6:0]  ireq_size;
    logic        iresp_valid = 1'b0;
    logic [31:0] iresp_data = '0;
    logic        out_valid;
    logic        bus_rdy = 1'b0;
    logic [31:0] out_data;
    logic        out_last;
    logic        out_disc;

    always #10 clk = ~clk;

    tgt_rd_disc_ctrl i_tgt_rd_disc_ctrl (
        .clk(clk), .rst_n(rst_n), .swap_en(swap_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_is_dram(req_is_dram), .fifo_flush(fifo_flush),
        .ireq_valid(ireq_valid), .ireq_ready(ireq_ready), .ireq_addr(ireq_addr),
        .ireq_size(ireq_size), .iresp_valid(iresp_valid), .iresp_data(iresp_data),
        .out_valid(out_valid), .bus_rdy(bus_rdy), .out_data(out_data),
        .out_last(out_last), .out_disc(out_disc)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit stall = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_phase = 0;      // 0 idle, 1 flush, 2 issue, 3 transfer
    int m_addr = 0;
    int m_start = 0;
    int m_left = 0;
    int m_grant = 0;
    bit m_disc = 1'b0;
    bit m_dram = 1'b0;
    int m_buf = 0;
    int mem_pend[$];

    function automatic logic [31:0] mem_word(input int a);
        logic [31:0] x;
        x = 32'(a) * 32'h9E3779B1;
        return x ^ 32'h0F1E2D3C;
    endfunction

    function automatic logic [31:0] rev_bytes(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // compare on every clock, then advance the model by one edge
    always @(negedge clk) begin
        bit ev;
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_up();
        end
        ev = (m_phase == 3) && (m_buf > 0);
        check("R1 req_ready", 32'(req_ready), 32'(m_phase == 0));
        check("R2 fifo_flush", 32'(fifo_flush), 32'(m_phase == 1));
        check("R3 ireq_valid", 32'(ireq_valid), 32'(m_phase == 2));
        if (m_phase == 2) begin
            check("R3 ireq_addr", ireq_addr, 32'(m_start));
            check("R6 ireq_size", 32'(ireq_size), 32'(m_grant * 4));
        end
        check("R9 out_valid", 32'(out_valid), 32'(ev));
        if (ev) begin
            if (swap_en) check("R8 out_data", out_data, rev_bytes(mem_word(m_addr)));
            else         check("R10 out_data", out_data, mem_word(m_addr));
            check("R7 out_last", 32'(out_last), 32'(m_left == 1));
            if (m_disc && m_left == 1)
                check(m_dram ? "R4 out_disc" : "R5 out_disc", 32'(out_disc), 32'd1);
            else
                check("R7 out_disc", 32'(out_disc), 32'd0);
        end else begin
            check("R7 out_last idle", 32'(out_last), 32'd0);
            check("R7 out_disc idle", 32'(out_disc), 32'd0);
        end

        if (!rst_n) begin
            m_phase = 0;
            m_buf = 0;
        end else begin
            case (m_phase)
                0: if (req_valid) begin
                    int eff, tob, lim, a;
                    a = int'(req_addr) & ~3;
                    eff = (req_len == 0) ? 1 : int'(req_len);
                    tob = (64 - (a % 64)) / 4;
                    lim = req_is_dram ? ((tob < 4) ? tob : 4) : tob;
                    m_grant = (eff < lim) ? eff : lim;
                    m_disc = (eff > lim);
                    m_dram = req_is_dram;
                    m_start = a;
                    m_addr = a;
                    m_left = m_grant;
                    m_phase = 1;
                end
                1: begin
                    m_buf = 0;
                    m_phase = 2;
                end
                2: if (ireq_ready) begin
                    for (int i = 0; i < m_grant; i++) mem_pend.push_back(m_start + 4 * i);
                    m_phase = 3;
                end
                default: begin
                    if (iresp_valid) m_buf++;
                    if (ev && bus_rdy) begin
                        m_buf--;
                        m_left--;
                        m_addr += 4;
                        if (m_left == 0) m_phase = 0;
                    end
                end
            endcase
        end
    end

    // memory model and bus-side handshake pattern
    always @(posedge clk) begin
        #1;
        bus_rdy    <= stall ? ($urandom % 4 != 0) : 1'b1;
        ireq_ready <= stall ? ($urandom % 2 == 0) : 1'b1;
        if (mem_pend.size() > 0 && (!stall || ($urandom % 3 != 0))) begin
            iresp_valid <= 1'b1;
            iresp_data  <= mem_word(mem_pend.pop_front());
        end else begin
            iresp_valid <= 1'b0;
        end
    end

    task automatic do_txn(input int addr, input int len, input bit dram, input bit sw);
        bit ok;
        do begin
            @(negedge clk);
        end while (!req_ready || m_phase != 0);
        @(posedge clk);
        #1;
        swap_en     = sw;
        req_addr    = 32'(addr);
        req_len     = 5'(len);
        req_is_dram = dram;
        req_valid   = 1'b1;
        do begin
            @(negedge clk);
            ok = req_ready;
            @(posedge clk);
            #1;
        end while (!ok);
        req_valid = 1'b0;
    endtask

    task automatic scenario_set();
        do_txn(32'h000, 8, 1, 0);    // R4: 32-byte DRAM read, first piece at 0x00
        do_txn(32'h010, 4, 1, 0);    // R4: second piece at 0x10
        do_txn(32'h030, 10, 0, 1);   // R5: offset start, boundary at 0x40
        do_txn(32'h004, 20, 0, 0);   // R5: 15 beats to boundary
        do_txn(32'h000, 16, 0, 1);   // R6: exact fit, no disconnect
        do_txn(32'h100, 2, 1, 0);    // R6: short DRAM read
        do_txn(32'h208, 0, 0, 1);    // R6: zero length served as one
        do_txn(32'h03C, 8, 1, 0);    // R5: DRAM read one word before boundary
        do_txn(32'h03D, 3, 0, 0);    // R3: low address bits dropped
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        scenario_set();
        stall = 1'b1;
        scenario_set();
        for (int k = 0; k < 40; k++)
            do_txn(int'($urandom % 1024), int'($urandom % 32), bit'($urandom % 2), bit'($urandom % 2));
        stall = 1'b0;
        do begin
            @(negedge clk);
        end while (m_phase != 0);
        repeat (5) @(negedge clk);
        finish_up();
    end

endmodule